// File: doc/BRIEF.md
# Iterative Fibonacci Sequencer

This block computes the Fibonacci number fib(n) for an unsigned count `n`. It uses two running-value registers and a down-counter, and it performs one addition per clock. The block waits while `ready` is high. A one-cycle `start` pulse captures `n`, and a short operate phase then steps the sequence. The block then raises `done` for a single cycle with the result on `f` and goes back to waiting.

The sequence follows fib(0)=0, fib(1)=1, and each later term is the sum of the two terms before it: 0, 1, 1, 2, 3, 5, 8, 13 and so on. The sums are held in `FW`-bit registers, so a result that does not fit wraps silently. The block is a plain controller plus datapath, intended as a compact multi-cycle arithmetic unit.

Top module: `fib_seq`

## Requirements
- R1: While reset is held and right after it, `ready` is 1, `done` is 0 and `f` is 0.
- R2: A `start` of 1 sampled while `ready` is 1 launches a computation, and `ready` is 0 from the next cycle until the block is idle again.
- R3: With `n`=0 at launch, `done` rises on the clock edge right after the launch edge, with `f`=0, and the add loop is skipped.
- R4: With `n`>=1 at launch, `done` rises exactly n+1 clock edges after the launch edge: n cycles in the operate phase, then the done cycle.
- R5: In the cycle where `done` is 1, `f` equals fib(n) reduced modulo 2^FW, where fib(0)=0, fib(1)=1 and fib(i)=fib(i-1)+fib(i-2).
- R6: `done` stays high for exactly one cycle, and `ready` is 1 in the cycle that follows.
- R7: While a computation is running, `start` and changes on `n` are ignored. The result and its latency depend only on the `n` captured at launch.
- R8: `f` reads 0 in every cycle where `done` is 0.
- R9: Sums wrap modulo 2^FW with no overflow indication. With the default FW=20 and n=31, `f` is 297693.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| reset | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Launch request, sampled while ready |
| n | input | NW | Index of the requested term |
| f | output | FW | Result, valid while done is high, else 0 |
| ready | output | 1 | Block idle and able to accept start |
| done | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach from the ports is a launch request, or a new index, that arrives while a computation is still in flight. A correct block drops both without trace. To reach it, the stimulus keeps `start` high and drives a different index on every cycle of the run. It releases `start` only before the done cycle, and then checks that the result value and the latency match the index captured at launch. The sweep covers every index from 0 to 31, so it reaches the wrap-around results and the boundary counts 0 and 1, where the loop is skipped or ends at once.

// File: rtl/fib_seq.sv
module fib_seq #(
  parameter int NW = 5,
  parameter int FW = 20
) (
  input  logic          clk,
  input  logic          reset,
  input  logic          start,
  input  logic [NW-1:0] n,
  output logic [FW-1:0] f,
  output logic          ready,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_OP, S_DONE} phase_t;

  phase_t        phase;
  logic [FW-1:0] prev_v, cur_v;
  logic [NW-1:0] left;
  logic          last_step;

  assign last_step = (left <= NW'(1));

  always_ff @(posedge clk or posedge reset) begin
    if (reset) begin
      phase  <= S_IDLE;
      prev_v <= '0;
      cur_v  <= '0;
      left   <= '0;
    end else begin
      case (phase)
        S_IDLE: if (start) begin
          prev_v <= '0;
          cur_v  <= (n == '0) ? '0 : FW'(1);
          left   <= n;
          phase  <= (n == '0) ? S_DONE : S_OP;
        end
        S_OP: if (last_step) begin
          phase <= S_DONE;
        end else begin
          cur_v  <= cur_v + prev_v;
          prev_v <= cur_v;
          left   <= left - NW'(1);
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign ready = (phase == S_IDLE);
  assign done  = (phase == S_DONE);
  assign f     = done ? cur_v : '0;

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (reset)
    (ready && start) |=> !ready);

  assert_zero_skip_R3: assert property (@(posedge clk) disable iff (reset)
    (ready && start && n == '0) |=> (done && f == '0));

  assert_op_exit_R4: assert property (@(posedge clk) disable iff (reset)
    (phase == S_OP && last_step) |=> done);

  assert_count_down_R4: assert property (@(posedge clk) disable iff (reset)
    (phase == S_OP && !last_step) |=> (left == $past(left) - NW'(1)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (reset)
    done |=> (!done && ready));

  assert_hold_busy_R7: assert property (@(posedge clk) disable iff (reset)
    (phase == S_OP) |=> !ready);

endmodule

// File: tb/fib_seq_test.sv
module fib_seq_test;
  localparam int NW = 5;
  localparam int FW = 20;

  logic          clk = 1'b0;
  logic          reset = 1'b1;
  logic          start = 1'b0;
  logic [NW-1:0] n = '0;
  logic [FW-1:0] f;
  logic          ready, done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  fib_seq #(.NW(NW), .FW(FW)) uut (
    .clk(clk), .reset(reset), .start(start), .n(n),
    .f(f), .ready(ready), .done(done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint fib_mod(input int k);
    longint a = 0;
    longint b = 1;
    longint t;
    if (k == 0) return 0;
    for (int i = 1; i < k; i++) begin
      t = (a + b) % (longint'(1) << FW);
      a = b;
      b = t;
    end
    return b;
  endfunction

  task automatic run(input int idx, input bit disturb);
    int lat;
    lat = (idx == 0) ? 1 : idx + 1;
    @(negedge clk);
    start = 1'b1;
    n = NW'(idx);
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k < lat) begin
        chk("R4 done low before latency", done, 0);
        chk("R8 f zero while not done", f, 0);
        chk("R2 R7 not ready while busy", ready, 0);
      end else begin
        chk((idx == 0) ? "R3 done after one edge" : "R4 done at n+1", done, 1);
        chk((idx == 31) ? "R9 wrapped result" : "R5 result value", f, fib_mod(idx));
      end
      if (disturb && k < lat) begin
        start = 1'b1;
        n = NW'((idx * 7 + k * 3) % 32);
      end else begin
        start = 1'b0;
        n = NW'(idx);
      end
    end
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    chk("R6 ready after done", ready, 1);
    chk("R8 f zero after done", f, 0);
  endtask

  initial begin
    #1;
    chk("R1 ready in reset", ready, 1);
    chk("R1 done in reset", done, 0);
    chk("R1 f in reset", f, 0);
    repeat (3) @(negedge clk);
    reset = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", ready, 1);
    chk("R1 done after reset", done, 0);
    chk("R1 f after reset", f, 0);
    for (int i = 0; i < 32; i++) run(i, 1'b0);
    for (int i = 0; i < 32; i++) run(31 - i, 1'b1);
    chk("R9 constant fib 31 mod 2^20", fib_mod(31), 297693);
    run(31, 1'b0);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule